// File: doc/BRIEF.md
# Banked Byte Register File with Shared Window

This block is the data memory seen by a small 8-bit core. Its 9-bit address space is cut into four banks of 128 byte locations. A 2-bit bank select, taken from the core's status register, picks the bank for direct accesses. An access through offset zero is indirect: the address then comes from an 8-bit pointer value plus one extra bank-high bit.

Inside every bank the low offsets are not stored here. Reads and writes to them are passed out on a peripheral register port, carrying the full resolved address. The upper offsets are general-purpose byte storage. The top sixteen offsets of each bank are one shared window, so the same physical sixteen bytes appear in all four banks. The number of private storage bytes per bank is set by the parameter `PRIV_DEPTH` (0 to 80). Private storage starts at offset 20h. Any offset between the end of private storage and the shared window has no storage: it reads zero and ignores writes.

Every resolved address falls into one of four region classes: RG_NONE (no storage), RG_SFR (peripheral port), RG_PRIV (private bank bytes) and RG_SHARED (shared window). Writes land on the rising clock edge. Reads are combinational from the current address.

Top module: `banked_regfile`

## Requirements
- R1: A direct access (offset 01h–7Fh) addresses `{bank_sel, off}`, and each of the four banks holds its own private bytes at offsets 20h..20h+PRIV_DEPTH-1.
- R2: Offsets 01h–1Fh of any bank drive `sfr_rd` high, present the 9-bit resolved address on `sfr_addr` and return `sfr_rdata` on `rd_data`; `sfr_wr` follows `wr_en` for these offsets.
- R3: Offsets 70h–7Fh in all four banks access the same 16 bytes, so a value written through any bank reads back through every bank.
- R4: Offsets from 20h+PRIV_DEPTH up to 6Fh read 00h, and writes to them change nothing.
- R5: With `off` = 00h the address is `{ind_bank, ptr}` (bit 8 = `ind_bank`, bits 7:0 = `ptr`), for both reads and writes.
- R6: An indirect access whose resolved offset (bits 6:0) is 00h reads 00h, discards a write and asserts neither `sfr_rd` nor `sfr_wr`.
- R7: A write takes effect at the rising clock edge: before the edge the old value reads, and in the following cycle the new value reads.
- R8: While `rst_n` is low, all storage bytes are cleared to 00h.
- R9: `sfr_rd` and `sfr_wr` stay low for every address outside offsets 01h–1Fh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, clears storage |
| bank_sel | input | 2 | Bank for direct accesses |
| ind_bank | input | 1 | Address bit 8 for indirect accesses |
| ptr | input | 8 | Pointer value, address bits 7:0 for indirect accesses |
| off | input | 7 | Offset inside the bank; 00h selects indirect access |
| wr_en | input | 1 | Write strobe for the current address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data |
| sfr_addr | output | 9 | Resolved address for the peripheral port |
| sfr_rd | output | 1 | Peripheral port is addressed |
| sfr_wr | output | 1 | Peripheral port write strobe |
| sfr_wdata | output | 8 | Write data toward the peripheral port |
| sfr_rdata | input | 8 | Read data from the peripheral port |

## Verification
The properties assume that every input is settled to a known value before each rising edge. They also assume that `wr_en` is low while reset is held, because a write during reset would break the read-after-write rules. The stimulus changes all inputs only on falling edges, keeps `wr_en` low through both reset pulses, and never leaves `off`, `ptr` or the bank bits unknown. Peripheral read data is driven by the bench so that pass-through on `rd_data` can be compared with a chosen value.

// File: rtl/bregf_pkg.sv
package bregf_pkg;

    typedef enum logic [1:0] {
        RG_NONE,
        RG_SFR,
        RG_PRIV,
        RG_SHARED
    } region_e;

    localparam int OFF_W       = 7;
    localparam int ADDR_W      = 9;
    localparam int SFR_LAST    = 'h1F;
    localparam int GPR_BASE    = 'h20;
    localparam int SHARED_BASE = 'h70;
    localparam int SHARED_N    = 16;
    localparam int SH_IDX_W    = 4;
    localparam int NBANKS      = 4;

endpackage

// File: rtl/bregf_addr.sv
module bregf_addr
    import bregf_pkg::*;
#(
    parameter int PRIV_DEPTH = 80,
    parameter int PIDX_W     = 9
) (
    input  logic [1:0]          bank_sel,
    input  logic                ind_bank,
    input  logic [7:0]          ptr,
    input  logic [OFF_W-1:0]    off,
    output logic [ADDR_W-1:0]   addr,
    output region_e             region,
    output logic [PIDX_W-1:0]   priv_idx,
    output logic [SH_IDX_W-1:0] sh_idx
);

    logic             is_ind;
    logic [OFF_W-1:0] loc;
    int               loc_i;
    int               bank_i;

    assign is_ind = (off == '0);
    assign addr   = is_ind ? {ind_bank, ptr} : {bank_sel, off};
    assign loc    = addr[OFF_W-1:0];
    assign loc_i  = int'(loc);
    assign bank_i = int'(addr[ADDR_W-1:OFF_W]);
    assign sh_idx = loc[SH_IDX_W-1:0];

    always_comb begin
        if (loc_i == 0) begin
            region = RG_NONE;
        end else if (loc_i <= SFR_LAST) begin
            region = RG_SFR;
        end else if (loc_i >= SHARED_BASE) begin
            region = RG_SHARED;
        end else if (loc_i < GPR_BASE + PRIV_DEPTH) begin
            region = RG_PRIV;
        end else begin
            region = RG_NONE;
        end
    end

    assign priv_idx = PIDX_W'(bank_i * PRIV_DEPTH + loc_i - GPR_BASE);

endmodule

// File: rtl/bregf_store.sv
module bregf_store
    import bregf_pkg::*;
#(
    parameter int PRIV_DEPTH = 80,
    parameter int PIDX_W     = 9,
    parameter int DATA_W     = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_priv,
    input  logic                wr_sh,
    input  logic [PIDX_W-1:0]   priv_idx,
    input  logic [SH_IDX_W-1:0] sh_idx,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   priv_q,
    output logic [DATA_W-1:0]   sh_q
);

    localparam int PRIV_N = NBANKS * PRIV_DEPTH;

    logic [DATA_W-1:0] sh_mem [SHARED_N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SHARED_N; i++) begin
                sh_mem[i] <= '0;
            end
        end else if (wr_sh) begin
            sh_mem[sh_idx] <= wdata;
        end
    end

    assign sh_q = sh_mem[sh_idx];

    generate
        if (PRIV_N > 0) begin : g_priv
            logic [DATA_W-1:0] pmem [PRIV_N];
            logic              idx_ok;

            assign idx_ok = (int'(priv_idx) < PRIV_N);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < PRIV_N; i++) begin
                        pmem[i] <= '0;
                    end
                end else if (wr_priv && idx_ok) begin
                    pmem[priv_idx] <= wdata;
                end
            end

            assign priv_q = idx_ok ? pmem[priv_idx] : '0;
        end else begin : g_nopriv
            assign priv_q = '0;
        end
    endgenerate

endmodule

// File: rtl/bregf_sfr_gate.sv
module bregf_sfr_gate
    import bregf_pkg::*;
(
    input  region_e             region,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    output logic [ADDR_W-1:0]   sfr_addr,
    output logic                sfr_rd,
    output logic                sfr_wr
);

    always_comb begin
        sfr_rd   = 1'b0;
        sfr_wr   = 1'b0;
        sfr_addr = '0;
        if (region == RG_SFR) begin
            sfr_rd   = 1'b1;
            sfr_wr   = wr_en;
            sfr_addr = addr;
        end
    end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bregf_pkg::*;
#(
    parameter int PRIV_DEPTH = 80,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bank_sel,
    input  logic              ind_bank,
    input  logic [7:0]        ptr,
    input  logic [6:0]        off,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [8:0]        sfr_addr,
    output logic              sfr_rd,
    output logic              sfr_wr,
    output logic [DATA_W-1:0] sfr_wdata,
    input  logic [DATA_W-1:0] sfr_rdata
);

    localparam int PRIV_N = NBANKS * PRIV_DEPTH;
    localparam int PIDX_W = (PRIV_N > 1) ? $clog2(PRIV_N) : 1;

    logic [ADDR_W-1:0]   addr;
    region_e             region;
    logic [PIDX_W-1:0]   priv_idx;
    logic [SH_IDX_W-1:0] sh_idx;
    logic [DATA_W-1:0]   priv_q;
    logic [DATA_W-1:0]   sh_q;
    logic                wr_priv;
    logic                wr_sh;

    bregf_addr #(
        .PRIV_DEPTH (PRIV_DEPTH),
        .PIDX_W     (PIDX_W)
    ) u_addr (
        .bank_sel (bank_sel),
        .ind_bank (ind_bank),
        .ptr      (ptr),
        .off      (off),
        .addr     (addr),
        .region   (region),
        .priv_idx (priv_idx),
        .sh_idx   (sh_idx)
    );

    assign wr_priv = wr_en && (region == RG_PRIV);
    assign wr_sh   = wr_en && (region == RG_SHARED);

    bregf_store #(
        .PRIV_DEPTH (PRIV_DEPTH),
        .PIDX_W     (PIDX_W),
        .DATA_W     (DATA_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_priv  (wr_priv),
        .wr_sh    (wr_sh),
        .priv_idx (priv_idx),
        .sh_idx   (sh_idx),
        .wdata    (wr_data),
        .priv_q   (priv_q),
        .sh_q     (sh_q)
    );

    bregf_sfr_gate u_sfr (
        .region   (region),
        .wr_en    (wr_en),
        .addr     (addr),
        .sfr_addr (sfr_addr),
        .sfr_rd   (sfr_rd),
        .sfr_wr   (sfr_wr)
    );

    assign sfr_wdata = wr_data;

    always_comb begin
        unique case (region)
            RG_SFR:    rd_data = sfr_rdata;
            RG_PRIV:   rd_data = priv_q;
            RG_SHARED: rd_data = sh_q;
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
    parameter int PRIV_DEPTH = 80,
    parameter int DATA_W     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        bank_sel,
    input logic [6:0]        off,
    input logic [7:0]        ptr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic [8:0]        sfr_addr,
    input logic              sfr_rd,
    input logic              sfr_wr,
    input logic [DATA_W-1:0] sfr_rdata
);

    p_sfr_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_rd |-> (sfr_addr[6:0] != 7'h00 && sfr_addr[6:0] <= 7'h1F));

    p_sfr_wr_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_wr |-> (sfr_rd && wr_en));

    p_sfr_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_rd |-> (rd_data == sfr_rdata));

    p_ind_null_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (off == 7'h00 && ptr[6:0] == 7'h00) |-> (rd_data == '0 && !sfr_rd && !sfr_wr));

    p_gap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (off != 7'h00 && int'(off) >= 32 + PRIV_DEPTH && off < 7'h70) |-> (rd_data == '0));

    p_shared_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(off[6:4]) == 3'b111
         && off[6:4] == 3'b111 && off[3:0] == $past(off[3:0]))
        |-> (rd_data == $past(wr_data)));

    p_priv_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && off == $past(off) && bank_sel == $past(bank_sel)
         && off >= 7'h20 && int'(off) < 32 + PRIV_DEPTH)
        |-> (rd_data == $past(wr_data)));

endmodule

bind banked_regfile banked_regfile_chk #(
    .PRIV_DEPTH (PRIV_DEPTH),
    .DATA_W     (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bank_sel  (bank_sel),
    .off       (off),
    .ptr       (ptr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .sfr_addr  (sfr_addr),
    .sfr_rd    (sfr_rd),
    .sfr_wr    (sfr_wr),
    .sfr_rdata (sfr_rdata)
);

// File: tb/banked_regfile_test.sv
module banked_regfile_test;

    localparam int PD = 40;  // private bytes 20h..47h; 48h..6Fh empty

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bank_sel = '0;
    logic       ind_bank = 1'b0;
    logic [7:0] ptr = '0;
    logic [6:0] off = 7'h20;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [8:0] sfr_addr;
    logic       sfr_rd;
    logic       sfr_wr;
    logic [7:0] sfr_wdata;
    logic [7:0] sfr_rdata = '0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    banked_regfile #(.PRIV_DEPTH(PD)) uut (
        .clk (clk), .rst_n (rst_n), .bank_sel (bank_sel), .ind_bank (ind_bank),
        .ptr (ptr), .off (off), .wr_en (wr_en), .wr_data (wr_data),
        .rd_data (rd_data), .sfr_addr (sfr_addr), .sfr_rd (sfr_rd),
        .sfr_wr (sfr_wr), .sfr_wdata (sfr_wdata), .sfr_rdata (sfr_rdata)
    );

    // entry: {req[3:0], write, bank[1:0], off[6:0], data[7:0]}
    localparam int NV = 22;
    localparam logic [21:0] VEC [NV] = '{
        {4'd1, 1'b1, 2'd0, 7'h20, 8'h11},  // R1 setup
        {4'd1, 1'b1, 2'd1, 7'h20, 8'h22},
        {4'd1, 1'b1, 2'd2, 7'h20, 8'h33},
        {4'd1, 1'b1, 2'd3, 7'h20, 8'h44},
        {4'd1, 1'b0, 2'd0, 7'h20, 8'h11},  // R1 bank private bytes
        {4'd1, 1'b0, 2'd1, 7'h20, 8'h22},
        {4'd1, 1'b0, 2'd2, 7'h20, 8'h33},
        {4'd1, 1'b0, 2'd3, 7'h20, 8'h44},
        {4'd3, 1'b1, 2'd0, 7'h75, 8'hA0},  // R3 shared window
        {4'd3, 1'b0, 2'd1, 7'h75, 8'hA0},
        {4'd3, 1'b1, 2'd1, 7'h75, 8'hA1},
        {4'd3, 1'b1, 2'd2, 7'h75, 8'hA2},
        {4'd3, 1'b1, 2'd3, 7'h75, 8'hA3},
        {4'd3, 1'b0, 2'd0, 7'h75, 8'hA3},
        {4'd3, 1'b0, 2'd1, 7'h75, 8'hA3},
        {4'd3, 1'b0, 2'd2, 7'h75, 8'hA3},
        {4'd3, 1'b0, 2'd3, 7'h75, 8'hA3},
        {4'd4, 1'b1, 2'd0, 7'h47, 8'h5A},  // R4 last private byte
        {4'd4, 1'b0, 2'd0, 7'h47, 8'h5A},
        {4'd4, 1'b1, 2'd2, 7'h48, 8'h77},  // R4 first empty byte
        {4'd4, 1'b0, 2'd2, 7'h48, 8'h00},
        {4'd4, 1'b0, 2'd2, 7'h6F, 8'h00}
    };

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] b, input logic [6:0] o, input logic ib,
                         input logic [7:0] p, input logic we, input logic [7:0] d);
        @(negedge clk);
        bank_sel = b; off = o; ind_bank = ib; ptr = p; wr_en = we; wr_data = d;
        #2;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8 reset state
        drive(2'd0, 7'h20, 1'b0, 8'h00, 1'b0, 8'h00);
        chk("R8", {1'b0, rd_data}, 9'h000);
        drive(2'd3, 7'h7F, 1'b0, 8'h00, 1'b0, 8'h00);
        chk("R8", {1'b0, rd_data}, 9'h000);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][16:15], VEC[i][14:8], 1'b0, 8'h00, VEC[i][17], VEC[i][7:0]);
            if (!VEC[i][17]) begin
                chk($sformatf("R%0d", VEC[i][21:18]), {1'b0, rd_data}, {1'b0, VEC[i][7:0]});
                chk("R9", {8'h00, sfr_rd}, 9'h000);
            end
        end

        // R2 peripheral window
        sfr_rdata = 8'hC3;
        drive(2'd2, 7'h05, 1'b0, 8'h00, 1'b0, 8'h00);
        chk("R2", {1'b0, rd_data}, 9'h0C3);
        chk("R2", sfr_addr, 9'h105);
        chk("R2", {8'h00, sfr_rd}, 9'h001);
        drive(2'd1, 7'h1F, 1'b0, 8'h00, 1'b1, 8'h6E);
        chk("R2", {8'h00, sfr_wr}, 9'h001);
        chk("R2", sfr_addr, 9'h09F);
        chk("R2", {1'b0, sfr_wdata}, 9'h06E);
        // R9 storage write gives no strobe
        drive(2'd1, 7'h21, 1'b0, 8'h00, 1'b1, 8'h3C);
        chk("R9", {7'h00, sfr_rd, sfr_wr}, 9'h000);

        // R5 indirect read: {1, 20h} = bank 2 offset 20h
        drive(2'd0, 7'h00, 1'b1, 8'h20, 1'b0, 8'h00);
        chk("R5", {1'b0, rd_data}, 9'h033);
        // R5 indirect write: {0, F5h} = bank 1 offset 75h, shared
        drive(2'd0, 7'h00, 1'b0, 8'hF5, 1'b1, 8'h5C);
        drive(2'd3, 7'h75, 1'b0, 8'h00, 1'b0, 8'h00);
        chk("R5", {1'b0, rd_data}, 9'h05C);
        // R5 indirect write to bank 3 offset 21h
        drive(2'd0, 7'h00, 1'b1, 8'hA1, 1'b1, 8'h99);
        drive(2'd3, 7'h21, 1'b0, 8'h00, 1'b0, 8'h00);
        chk("R5", {1'b0, rd_data}, 9'h099);
        // R5 indirect into peripheral window: {1, 83h} -> 183h
        drive(2'd0, 7'h00, 1'b1, 8'h83, 1'b0, 8'h00);
        chk("R5", sfr_addr, 9'h183);

        // R6 indirect onto offset 00h
        drive(2'd0, 7'h00, 1'b1, 8'h80, 1'b1, 8'hEE);
        chk("R6", {1'b0, rd_data}, 9'h000);
        chk("R6", {7'h00, sfr_rd, sfr_wr}, 9'h000);
        drive(2'd0, 7'h00, 1'b0, 8'h00, 1'b0, 8'h00);
        chk("R6", {1'b0, rd_data}, 9'h000);
        drive(2'd3, 7'h20, 1'b0, 8'h00, 1'b0, 8'h00);
        chk("R6", {1'b0, rd_data}, 9'h044);

        // R7 write edge timing
        drive(2'd0, 7'h30, 1'b0, 8'h00, 1'b1, 8'hE1);
        chk("R7", {1'b0, rd_data}, 9'h000);
        drive(2'd0, 7'h30, 1'b0, 8'h00, 1'b0, 8'h00);
        chk("R7", {1'b0, rd_data}, 9'h0E1);

        // R8 reset clears written bytes
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        drive(2'd0, 7'h20, 1'b0, 8'h00, 1'b0, 8'h00);
        chk("R8", {1'b0, rd_data}, 9'h000);
        drive(2'd2, 7'h75, 1'b0, 8'h00, 1'b0, 8'h00);
        chk("R8", {1'b0, rd_data}, 9'h000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule